// File: doc/BRIEF.md
# Conversion Sequencer Freeze Controller

This block steps a conversion sequencer through a fixed number of digital steps and decides how that sequencer reacts to a debug freeze request. A two-bit mode value comes from a configuration register held elsewhere. It selects one of three responses. The request can be disregarded. The running conversion can be allowed to finish, with the freeze taking hold afterwards. Or the sequencer can be halted at once, even partway through a step. While halted, the shared clock enable is withdrawn, so every sequential element keeps its value. The busy flag and the step index stay valid and visible on the ports the whole time.

A separate stop input halts the sequencer in a known place. When the stop input rises partway through a step, that step is allowed to complete, and the sequencer then holds at the start of the next step. When it is idle, it holds at once. A request to stop the clock for the whole system does not drive this input. When a freeze or stop is released, the sequencer carries on by itself from where it halted. It does not restart the conversion.

Top module: `cvseq_freeze_ctrl`

## Requirements
- R1: After reset the sequencer is idle: busy_o=0, step_o=0, done_o=0, frozen_o=0, stopped_o=0 and clk_en_o=1.
- R2: A start_i sampled high at an enabled clock edge while idle begins a conversion. The sequencer is then busy for NUM_STEPS*STEP_CYCLES enabled cycles, and step_o advances by one every STEP_CYCLES enabled cycles, starting at 0. A start_i sampled while busy has no effect.
- R3: done_o is high for exactly one cycle, in the last enabled cycle of the final step. busy_o is low in the following cycle.
- R4: Mode values 2'b00 and 2'b01 ignore freeze_req_i. frozen_o stays low and the conversion completes on its normal schedule.
- R5: With mode 2'b11, frozen_o is high in every cycle in which freeze_req_i is high, including partway through a step. After release, the conversion continues from the halted position, and the next step index follows the one that was held.
- R6: With mode 2'b10, a request that arrives during a conversion does not freeze it. frozen_o rises in the first idle cycle after done_o, provided the request is still high.
- R7: With mode 2'b10 and the sequencer idle, frozen_o follows freeze_req_i in the same cycle, and start_i has no effect while frozen.
- R8: clk_en_o is low exactly in the cycles in which frozen_o or stopped_o is high.
- R9: While frozen, busy_o and step_o hold their values.
- R10: When stop_i is high partway through a step, the sequencer finishes that step and then holds at the next step boundary with stopped_o high. When stop_i is high while idle, the sequencer holds at once and start_i is ignored. Release resumes without loss of position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frz_mode_i | input | 2 | Freeze response: 00/01 ignore, 10 after conversion, 11 at once |
| freeze_req_i | input | 1 | Debug freeze request |
| stop_i | input | 1 | Stop bit from the configuration register |
| start_i | input | 1 | Conversion start request |
| busy_o | output | 1 | Conversion in progress |
| step_o | output | STEP_W | Current step index |
| done_o | output | 1 | One-cycle pulse as the final step completes |
| frozen_o | output | 1 | Sequencer frozen by the debug request |
| stopped_o | output | 1 | Sequencer held by the stop bit |
| clk_en_o | output | 1 | Shared clock enable for the sequencer |

## Verification
The bench freezes in mode 11 on the second half of a step. A design that restarted the step or the conversion would be late with done_o, and a design that skipped ahead would show the wrong step index after release. In mode 10 a request is raised mid-conversion and held. A design that froze early would push done_o past its expected cycle, and one that never froze afterwards would leave frozen_o low while idle and would accept a start. The stop bit is raised partway through a step, which separates a design that halts immediately from one that halts at the boundary. The two ignore encodings are each driven with a live request.

// File: rtl/cvseq_pkg.sv
package cvseq_pkg;

  typedef enum logic [1:0] {
    FRZ_IGNORE     = 2'b00,
    FRZ_RSVD       = 2'b01,
    FRZ_AFTER_CONV = 2'b10,
    FRZ_AT_ONCE    = 2'b11
  } frz_mode_e;

  // Whether a freeze request halts the sequencer this cycle.
  function automatic logic frz_applies(input frz_mode_e mode,
                                       input logic req,
                                       input logic busy);
    case (mode)
      FRZ_AT_ONCE:    return req;
      FRZ_AFTER_CONV: return req && !busy;
      default:        return 1'b0;
    endcase
  endfunction

  // Stop only takes hold on a step boundary.
  function automatic logic stop_applies(input logic stop,
                                        input logic mid_step);
    return stop && !mid_step;
  endfunction

  // Width helper that never yields zero.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cvseq_frz_decode.sv
module cvseq_frz_decode
  import cvseq_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       req_i,
  input  logic       busy_i,
  output logic       freeze_hit_o
);

  frz_mode_e mode;

  always_comb begin
    mode         = frz_mode_e'(mode_i);
    freeze_hit_o = frz_applies(mode, req_i, busy_i);
  end

endmodule

// File: rtl/cvseq_clk_gate.sv
module cvseq_clk_gate
  import cvseq_pkg::*;
(
  input  logic freeze_hit_i,
  input  logic stop_i,
  input  logic mid_step_i,
  output logic clk_en_o,
  output logic frozen_o,
  output logic stopped_o
);

  logic stop_hit;

  always_comb begin
    stop_hit  = stop_applies(stop_i, mid_step_i);
    frozen_o  = freeze_hit_i;
    stopped_o = stop_hit;
    clk_en_o  = !(freeze_hit_i || stop_hit);
  end

endmodule

// File: rtl/cvseq_step_ctr.sv
module cvseq_step_ctr
  import cvseq_pkg::*;
#(
  parameter  int unsigned NUM_STEPS   = 8,
  parameter  int unsigned STEP_CYCLES = 2,
  localparam int unsigned STEP_W      = idx_width(NUM_STEPS),
  localparam int unsigned TICK_W      = idx_width(STEP_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic [STEP_W-1:0] step_o,
  output logic              mid_step_o,
  output logic              conv_done_o
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic              tick_last;
  logic              step_last;

  assign step_last = (step_q == LAST_STEP);

  generate
    if (STEP_CYCLES > 1) begin : g_multi_tick
      localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(STEP_CYCLES - 1);
      logic [TICK_W-1:0] tick_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tick_q <= '0;
        end else if (en_i && busy_q) begin
          tick_q <= (tick_q == LAST_TICK) ? '0 : tick_q + 1'b1;
        end
      end

      assign tick_last  = (tick_q == LAST_TICK);
      assign mid_step_o = busy_q && (tick_q != '0);
    end else begin : g_single_tick
      assign tick_last  = 1'b1;
      assign mid_step_o = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (en_i) begin
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          step_q <= '0;
        end
      end else if (tick_last) begin
        if (step_last) begin
          busy_q <= 1'b0;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign step_o      = step_q;
  assign conv_done_o = en_i && busy_q && tick_last && step_last;

endmodule

// File: rtl/cvseq_freeze_ctrl.sv
module cvseq_freeze_ctrl
  import cvseq_pkg::*;
#(
  parameter  int unsigned NUM_STEPS   = 8,
  parameter  int unsigned STEP_CYCLES = 2,
  localparam int unsigned STEP_W      = idx_width(NUM_STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        frz_mode_i,
  input  logic              freeze_req_i,
  input  logic              stop_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o,
  output logic              frozen_o,
  output logic              stopped_o,
  output logic              clk_en_o
);

  // Named internal events, also used by the bound checker.
  logic ev_freeze_hit;
  logic ev_mid_step;
  logic ev_conv_done;
  logic ev_clk_en;
  logic busy_w;

  cvseq_frz_decode i_decode (
    .mode_i       (frz_mode_i),
    .req_i        (freeze_req_i),
    .busy_i       (busy_w),
    .freeze_hit_o (ev_freeze_hit)
  );

  cvseq_clk_gate i_gate (
    .freeze_hit_i (ev_freeze_hit),
    .stop_i       (stop_i),
    .mid_step_i   (ev_mid_step),
    .clk_en_o     (ev_clk_en),
    .frozen_o     (frozen_o),
    .stopped_o    (stopped_o)
  );

  cvseq_step_ctr #(
    .NUM_STEPS   (NUM_STEPS),
    .STEP_CYCLES (STEP_CYCLES)
  ) i_steps (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (ev_clk_en),
    .start_i     (start_i),
    .busy_o      (busy_w),
    .step_o      (step_o),
    .mid_step_o  (ev_mid_step),
    .conv_done_o (ev_conv_done)
  );

  assign busy_o   = busy_w;
  assign done_o   = ev_conv_done;
  assign clk_en_o = ev_clk_en;

endmodule

// File: rtl/cvseq_freeze_chk.sv
module cvseq_freeze_chk #(
  parameter int unsigned STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        frz_mode_i,
  input logic              freeze_req_i,
  input logic              busy_o,
  input logic [STEP_W-1:0] step_o,
  input logic              done_o,
  input logic              frozen_o,
  input logic              stopped_o,
  input logic              clk_en_o,
  input logic              ev_mid_step
);

  // R2
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R4
  ignore_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_mode_i == 2'b00 || frz_mode_i == 2'b01) |-> !frozen_o);

  // R5
  freeze_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_mode_i == 2'b11 && freeze_req_i) |-> frozen_o);

  // R6
  after_conv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_mode_i == 2'b10 && busy_o) |-> !frozen_o);

  // R8
  frozen_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_o || stopped_o) |-> !clk_en_o);

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_o |=> ($stable(step_o) && $stable(busy_o)));

  // R10
  stop_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped_o |-> !ev_mid_step);

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped_o |=> ($stable(step_o) && $stable(busy_o)));

endmodule

bind cvseq_freeze_ctrl cvseq_freeze_chk #(.STEP_W(STEP_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frz_mode_i   (frz_mode_i),
  .freeze_req_i (freeze_req_i),
  .busy_o       (busy_o),
  .step_o       (step_o),
  .done_o       (done_o),
  .frozen_o     (frozen_o),
  .stopped_o    (stopped_o),
  .clk_en_o     (clk_en_o),
  .ev_mid_step  (ev_mid_step)
);

// File: tb/test_cvseq_freeze_ctrl.sv
`timescale 1ns/100ps
module test_cvseq_freeze_ctrl;

  localparam int NSTEP = 8;
  localparam int SCYC  = 2;
  localparam int CONV  = NSTEP * SCYC;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] frz_mode_i = 2'b00;
  logic       freeze_req_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       start_i = 1'b0;
  logic       busy_o, done_o, frozen_o, stopped_o, clk_en_o;
  logic [2:0] step_o;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cvseq_freeze_ctrl #(.NUM_STEPS(NSTEP), .STEP_CYCLES(SCYC)) i_cvseq_freeze_ctrl (
    .clk(clk), .rst_n(rst_n), .frz_mode_i(frz_mode_i), .freeze_req_i(freeze_req_i),
    .stop_i(stop_i), .start_i(start_i), .busy_o(busy_o), .step_o(step_o),
    .done_o(done_o), .frozen_o(frozen_o), .stopped_o(stopped_o), .clk_en_o(clk_en_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Driver: request a conversion and push the cycle in which done must show.
  task automatic launch(input int extra);
    start_i = 1'b1;
    exp_q.push_back(cyc + CONV + extra);
    tick(1);
    start_i = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && exp_q.size() != 0; k++) tick(1);
    chk(exp_q.size() == 0, "R3 done never seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // Monitor: pop expectations as done pulses appear.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R3 unexpected done", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R3 done cycle", cyc, e);
      end
    end
  end

  task automatic ignore_test(input logic [1:0] mode);
    frz_mode_i = mode;
    launch(0);
    tick(2);
    freeze_req_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!frozen_o && clk_en_o, "R4 ignore mode frozen", frozen_o, 0);
      tick(1);
    end
    freeze_req_i = 1'b0;
    drain();
    tick(1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy_o && step_o == 0 && !done_o, "R1 reset idle", busy_o, 0);
    chk(!frozen_o && !stopped_o && clk_en_o, "R1 reset gate", clk_en_o, 1);
    tick(1);

    // R2: plain conversion, start while busy ignored
    launch(0);
    tick(2);
    start_i = 1'b1;
    @(negedge clk);
    chk(step_o == 1 && busy_o, "R2 step progress", step_o, 1);
    tick(1);
    start_i = 1'b0;
    drain();
    @(negedge clk);
    chk(!busy_o, "R3 idle after done", busy_o, 0);
    tick(1);

    // R4: both ignore encodings
    ignore_test(2'b00);
    ignore_test(2'b01);

    // R5/R9/R8: immediate freeze on second half of step 1
    frz_mode_i = 2'b11;
    launch(4);
    tick(3);
    freeze_req_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(frozen_o, "R5 frozen at once", frozen_o, 1);
      chk(!clk_en_o, "R8 enable low while frozen", clk_en_o, 0);
      chk(step_o == 1 && busy_o, "R9 status held", step_o, 1);
      tick(1);
    end
    freeze_req_i = 1'b0;
    @(negedge clk);
    chk(!frozen_o && clk_en_o && step_o == 1, "R8 enable back", clk_en_o, 1);
    tick(1);
    @(negedge clk);
    chk(step_o == 2, "R5 resume next step", step_o, 2);
    drain();
    tick(1);

    // R6: after-conversion freeze
    frz_mode_i = 2'b10;
    launch(0);
    tick(4);
    freeze_req_i = 1'b1;
    for (int k = 0; k < 100 && exp_q.size() != 0; k++) begin
      @(negedge clk);
      if (exp_q.size() != 0) chk(!frozen_o, "R6 no freeze while busy", frozen_o, 0);
      tick(1);
    end
    @(negedge clk);
    chk(frozen_o && !busy_o && !clk_en_o, "R6 freeze after done", frozen_o, 1);
    tick(1);
    start_i = 1'b1;
    tick(2);
    @(negedge clk);
    chk(!busy_o, "R7 start ignored while frozen", busy_o, 0);
    start_i = 1'b0;
    freeze_req_i = 1'b0;
    @(negedge clk);
    chk(!frozen_o && clk_en_o, "R6 release", frozen_o, 0);
    tick(1);

    // R7: idle freeze in mode 10
    freeze_req_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    chk(frozen_o, "R7 idle freeze same cycle", frozen_o, 1);
    tick(2);
    @(negedge clk);
    chk(!busy_o, "R7 start blocked", busy_o, 0);
    start_i = 1'b0;
    freeze_req_i = 1'b0;
    tick(1);

    // R10: stop partway through step 1
    frz_mode_i = 2'b00;
    launch(3);
    tick(3);
    stop_i = 1'b1;
    @(negedge clk);
    chk(!stopped_o && clk_en_o, "R10 finish step first", stopped_o, 0);
    tick(1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(stopped_o && !clk_en_o, "R10 stopped at boundary", stopped_o, 1);
      chk(step_o == 2 && busy_o, "R10 held at next step", step_o, 2);
      tick(1);
    end
    stop_i = 1'b0;
    @(negedge clk);
    chk(!stopped_o && step_o == 2, "R10 resume", step_o, 2);
    drain();
    tick(1);

    // R10: stop while idle
    stop_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    chk(stopped_o, "R10 idle stop", stopped_o, 1);
    tick(2);
    @(negedge clk);
    chk(!busy_o, "R10 start ignored while stopped", busy_o, 0);
    stop_i = 1'b0;
    start_i = 1'b0;
    tick(2);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule